// File: doc/BRIEF.md
# Serial Line Encoder with Preamble

This block turns a stream of transmit bits into a single serial line. Bits arrive one at a time through a valid/ready handshake. They are coded as plain NRZ, NRZI (mark or space), FM0, FM1, Manchester or differential Manchester. A clock enable that pulses at twice the bit rate paces the block: the first pulse of each pair opens a bit cell and the second marks its middle.

A frame begins when data is offered while the block is idle. When the preamble is enabled, a fixed 8-bit lock pattern goes out first, and the pattern depends on the selected code. The handshake stays closed until the whole pattern has gone out. When no data is offered at a bit boundary, the frame ends. The line then either sits high or keeps carrying coded ones. Accepted data bits may be inverted before they are coded.

Top module: `line_encoder`

## Requirements
- R1: After reset, `tx_line` is 1 and `in_ready` is 0.
- R2: `in_ready` is high only in a cycle where `half_en` opens a bit cell, and only in the data phase or while idle with the preamble disabled. A bit is taken when `in_valid` and `in_ready` are both high.
- R3: With `pre_en` set, data offered while idle starts a preamble of `PRE_BITS` (8) bits. No bit is taken until all of them have gone out, and `in_ready` stays 0 throughout.
- R4: Preamble pattern by `code`: 5 (Manchester) and 0/7 (NRZ) send 1,0,1,0... starting with 1. Codes 1 (NRZI mark) and 4 (FM1) send all zeros. Codes 2 (NRZI space), 3 (FM0) and 6 (differential Manchester) send all ones.
- R5: Code 0 (and 7) is NRZ: the line equals the bit for the whole cell. Code 1 toggles the line at the cell start for a 1, and code 2 toggles it for a 0. Neither changes the line mid-cell.
- R6: Codes 3 and 4 always toggle at the cell start. Mid-cell, code 3 toggles for a 0 and code 4 toggles for a 1.
- R7: Code 5 drives the bit in the first half of the cell and its complement in the second half. Code 6 always toggles mid-cell, and toggles at the cell start for a 0.
- R8: With `invert` set, each accepted data bit is complemented before coding. Preamble and idle bits are not affected.
- R9: A bit boundary in the data phase with `in_valid` low ends the frame. While idle, `idle_high` set holds the line at 1 from that cell start. When it is clear, the line carries coded 1 bits.
- R10: `tx_line` changes only in the cycle after a `half_en` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | Enable pulse at twice the bit rate |
| code | input | 3 | Line code select (see R4 to R7) |
| pre_en | input | 1 | Send a preamble before each frame |
| idle_high | input | 1 | Hold the line high while idle |
| invert | input | 1 | Complement accepted data bits |
| in_valid | input | 1 | A transmit bit is offered |
| in_bit | input | 1 | The offered bit |
| in_ready | output | 1 | Bit is taken this cycle |
| tx_line | output | 1 | Serial output line |

## Verification
`in_ready` is combinational and is due in the same cycle as the `half_en` pulse that opens a cell. The bench drives inputs at the falling edge and samples `in_ready` one time step later. Each line level is due one cycle after its `half_en` pulse: the cell-start level after the first pulse, the mid-cell level after the second. The reference model updates its expected level when it sees the pulse and compares it at the next falling edge, so every expected value lines up with the register that produces it. Configuration is changed only between frames, at a point where the next pulse opens a cell.

// File: rtl/line_encoder.sv
module line_encoder #(
  parameter int PRE_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_en,
  input  logic [2:0] code,
  input  logic       pre_en,
  input  logic       idle_high,
  input  logic       invert,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       tx_line
);

  localparam int CW = (PRE_BITS > 2) ? $clog2(PRE_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic         ph, lvl, forced, cur;
  logic         bound, take, send_pre, nb, nforce;
  logic [CW-1:0] idx;

  function automatic logic pre_pat(input logic [2:0] c, input logic [CW-1:0] i);
    case (c)
      3'd1, 3'd4:       pre_pat = 1'b0;
      3'd2, 3'd3, 3'd6: pre_pat = 1'b1;
      default:          pre_pat = ~i[0];
    endcase
  endfunction

  function automatic logic lvl_start(input logic [2:0] c, input logic l, input logic b);
    case (c)
      3'd1:       lvl_start = l ^ b;
      3'd2:       lvl_start = l ^ ~b;
      3'd3, 3'd4: lvl_start = ~l;
      3'd6:       lvl_start = b ? l : ~l;
      default:    lvl_start = b;
    endcase
  endfunction

  function automatic logic lvl_mid(input logic [2:0] c, input logic l, input logic b);
    case (c)
      3'd3:    lvl_mid = b ? l : ~l;
      3'd4:    lvl_mid = b ? ~l : l;
      3'd5:    lvl_mid = ~b;
      3'd6:    lvl_mid = ~l;
      default: lvl_mid = l;
    endcase
  endfunction

  assign bound    = half_en && !ph;
  assign in_ready = bound && (st == S_DATA || (st == S_IDLE && !pre_en));
  assign take     = in_ready && in_valid;
  assign send_pre = bound && (st == S_PRE || (st == S_IDLE && in_valid && pre_en));
  assign idx      = (st == S_PRE) ? cnt : '0;
  assign nb       = send_pre ? pre_pat(code, idx) : take ? (in_bit ^ invert) : 1'b1;
  assign nforce   = !send_pre && !take && idle_high;
  assign tx_line  = lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ph     <= 1'b0;
      lvl    <= 1'b1;
      forced <= 1'b1;
      cur    <= 1'b1;
    end else if (half_en) begin
      ph <= ~ph;
      if (!ph) begin
        cur    <= nb;
        forced <= nforce;
        lvl    <= nforce ? 1'b1 : lvl_start(code, lvl, nb);
        if (send_pre) begin
          if (st == S_IDLE) begin
            st  <= S_PRE;
            cnt <= CW'(1);
          end else if (cnt == LAST) begin
            st  <= S_DATA;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end else if (take) begin
          st <= S_DATA;
        end else begin
          st <= S_IDLE;
        end
      end else if (!forced) begin
        lvl <= lvl_mid(code, lvl, cur);
      end
    end
  end

  p_ready_on_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (half_en && !ph));

  p_no_ready_in_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE) |-> !in_ready);

  p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(tx_line));

  p_forced_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    forced |-> tx_line);

  p_dm_mid_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && ph && code == 3'd6 && !forced) |=> (tx_line != $past(tx_line)));

endmodule

// File: tb/test_line_encoder.sv
module test_line_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0, half_en = 1'b0;
  logic [2:0] code = 3'd0;
  logic pre_en = 1'b0, idle_high = 1'b1, invert = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, tx_line;

  line_encoder #(.PRE_BITS(8)) i_line_encoder (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .code(code), .pre_en(pre_en),
    .idle_high(idle_high), .invert(invert), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .tx_line(tx_line));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int divv = 2, hc = 0;
  bit q[$];
  int m_st = 0, m_k = 0, m_ph = 0;
  bit m_tx = 1, m_h2 = 1;
  string m_tag = "R1";

  function automatic bit pre_exp(input int c, input int k);
    if (c == 1 || c == 4) return 0;
    if (c == 2 || c == 3 || c == 6) return 1;
    return (k % 2 == 0);
  endfunction

  function automatic string code_tag(input int c);
    if (c == 3 || c == 4) return "R6";
    if (c == 5 || c == 6) return "R7";
    return "R5";
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic tick();
    bit hv, er, b, forced, is_data, h1, h2, lv;
    int c;
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
    check(m_tag, tx_line, m_tx);
    hv = (hc == 0);
    hc = (hc + 1) % divv;
    half_en = hv;
    in_valid = (q.size() > 0);
    in_bit = (q.size() > 0) ? q[0] : 1'b0;
    #1;
    er = hv && m_ph == 0 && (m_st == 2 || (m_st == 0 && !pre_en));
    check((m_st == 1) ? "R3" : "R2", in_ready, er);
    c = code;
    if (!hv) begin
      m_tag = "R10";
      return;
    end
    if (m_ph == 1) begin
      m_tx = m_h2;
      m_ph = 0;
      return;
    end
    m_ph = 1;
    forced = 0; is_data = 0; b = 1;
    if (m_st == 1 || (m_st == 0 && in_valid && pre_en)) begin
      if (m_st == 0) m_k = 0;
      b = pre_exp(c, m_k);
      m_k++;
      m_st = (m_k == 8) ? 2 : 1;
      m_tag = "R4";
    end else if (er && in_valid) begin
      b = q.pop_front() ^ invert;
      is_data = 1;
      m_st = 2;
      m_tag = invert ? "R8" : code_tag(c);
    end else begin
      m_st = 0;
      forced = idle_high;
      m_tag = forced ? "R9" : code_tag(c);
    end
    lv = m_tx;
    if (forced) begin
      h1 = 1; h2 = 1;
    end else begin
      case (c)
        1: begin h1 = b ? !lv : lv; h2 = h1; end
        2: begin h1 = b ? lv : !lv; h2 = h1; end
        3: begin h1 = !lv; h2 = b ? h1 : !h1; end
        4: begin h1 = !lv; h2 = b ? !h1 : h1; end
        5: begin h1 = b; h2 = !b; end
        6: begin h1 = b ? lv : !lv; h2 = !h1; end
        default: begin h1 = b; h2 = b; end
      endcase
    end
    if (is_data && invert) m_tag = "R8";
    m_tx = h1;
    m_h2 = h2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", tx_line, 1'b1);
    check("R1", in_ready, 1'b0);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      for (int combo = 0; combo < 8; combo++) begin
        while (m_ph != 0) tick();
        code = 3'(c);
        invert = combo[0];
        pre_en = combo[1];
        idle_high = combo[2];
        divv = 1 + (combo + c) % 3;
        hc = 0;
        for (int f = 0; f < 2; f++) begin
          for (int i = 0; i < 11; i++) q.push_back(1'($urandom));
          while (q.size() > 0) tick();
          repeat (24) tick();
        end
      end
    end
    repeat (10) tick();
    finish_run();
  end
endmodule